// File: doc/BRIEF.md
# Iterative Radix-2 FFT Engine with One Shared Butterfly

This block transforms a frame of N complex samples into N frequency bins (or back) using a single radix-2 butterfly that is reused for every pair of every stage. It suits a narrowband receiver or transmitter with few subcarriers, where the clock runs much faster than the symbol rate and saving multipliers matters more than throughput. A start pulse arms the engine and latches the direction, either forward or inverse. The engine then takes the next N valid samples, runs log2(N) decimation-in-frequency passes, and streams the N results out in natural bin order.

Two data memories work as a ping-pong pair. Each pass reads operand pairs from one memory and writes the butterfly results into the other. The twiddle factors come from a phase-factor table that is computed at elaboration. Every butterfly output is halved, so the results carry an overall 1/N scale and cannot overflow. The last pass leaves the bins in bit-reversed positions, and the read-out reverses the address to put them back in order.

Top module: `fft_engine`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid, out_last and done are low and the engine is idle.
- R2: After a start pulse in the idle state, the next N cycles that have in_valid high supply samples x[0]..x[N-1] in that order. Cycles with in_valid low are skipped, and in_valid has no effect outside the loading phase.
- R3: With inverse low at start, output k (k = 0..N-1, sent in that order) equals (1/N)·Σ x[n]·e^(-j2πkn/N), to within 4 LSB on each of re and im, for inputs whose complex magnitude is below 2^(DW-1).
- R4: With inverse high at start, output k equals (1/N)·Σ x[n]·e^(+j2πkn/N), to the same tolerance.
- R5: The direction is sampled only at the start pulse. Changes on inverse after that do not affect the frame.
- R6: out_valid first rises exactly log2(N)·N/2 clock cycles after the edge that accepts the last input sample.
- R7: out_valid stays high for exactly N consecutive cycles, and out_last is high only on the N-th of them.
- R8: done is high for exactly one cycle, and that cycle is the one that carries the first output bin.
- R9: A start pulse is ignored while the engine is loading, computing or sending. The current frame completes unchanged, and the engine then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new frame when idle |
| inverse | input | 1 | 1 selects the inverse transform (sampled at start) |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output bin qualifier |
| out_last | output | 1 | Marks the final bin of a frame |
| out_re | output | DW | Output real part, signed |
| out_im | output | DW | Output imaginary part, signed |
| done | output | 1 | One-cycle flag marking the first output bin |

## Verification
The bench counts falling edges from the edge that takes the last sample and expects out_valid after exactly log2(N)·N/2 of them, which is 12 for the default N of 8. The bins then arrive on N consecutive cycles, one per cycle. The bench samples every output on the falling edge, half a cycle after the register that drives it changes, and changes the inputs only after it has sampled. That way each check sees the value that belongs to the intended cycle. Expected bins are computed in the bench as a direct DFT in real arithmetic and scaled by 1/N. The stimuli are impulses, DC, tones and a pseudo-random frame, in both directions. Further frames toggle inverse, pulse start and drive stray valid samples during the busy phases.

// File: rtl/fft_pkg.sv
package fft_pkg;

    localparam int DW  = 16;
    localparam int TWW = 16;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [TWW-1:0] re;
        logic signed [TWW-1:0] im;
    } twid_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_CALC  = 2'd2,
        ST_DRAIN = 2'd3
    } eng_state_t;

    // round a real value to the nearest integer, symmetric about zero
    function automatic int round_q(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(-x + 0.5);
    endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom
    import fft_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N) - 1
) (
    input  logic [IW-1:0] idx,
    output twid_t         w
);
    localparam int  HALFN = N / 2;
    localparam real SCL   = real'((1 << (TWW - 1)) - 1);
    localparam real TWO_PI = 6.283185307179586;

    twid_t tab [HALFN];

    // w[k] = exp(-j*2*pi*k/N) in signed Q(TWW-1)
    for (genvar k = 0; k < HALFN; k++) begin : g_tw
        localparam real ANG = TWO_PI * real'(k) / real'(N);
        assign tab[k].re = TWW'(round_q($cos(ANG) * SCL));
        assign tab[k].im = TWW'(round_q(-$sin(ANG) * SCL));
    end

    assign w = tab[idx];
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
    parameter int N  = 8,
    parameter int LG = $clog2(N),
    parameter int SW = $clog2(LG),
    parameter int BW = LG - 1
) (
    input  logic [SW-1:0] stage,
    input  logic [BW-1:0] bf,
    output logic [LG-1:0] idx_a,
    output logic [LG-1:0] idx_b,
    output logic [BW-1:0] tw_idx
);
    localparam int HALFN = N / 2;

    logic [LG-1:0] span;
    logic [LG-1:0] pos;
    logic [LG-1:0] grp;

    // decimation in frequency: stage s pairs elements N>>(s+1) apart
    always_comb begin
        span   = LG'(HALFN) >> stage;
        pos    = {1'b0, bf} & (span - 1'b1);
        grp    = {1'b0, bf} >> (LG - 1 - int'(stage));
        idx_a  = (grp << (LG - int'(stage))) | pos;
        idx_b  = idx_a | span;
        tw_idx = BW'(pos << stage);
    end
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly
    import fft_pkg::*;
(
    input  samp_t a,
    input  samp_t b,
    input  twid_t w,
    output samp_t p,
    output samp_t q
);
    localparam int SUMW = DW + 1;
    localparam int PW   = DW + TWW + 2;

    logic signed [SUMW-1:0] s_re, s_im, d_re, d_im;
    logic signed [PW-1:0]   m_re, m_im;

    always_comb begin
        s_re = SUMW'($signed(a.re)) + SUMW'($signed(b.re));
        s_im = SUMW'($signed(a.im)) + SUMW'($signed(b.im));
        d_re = SUMW'($signed(a.re)) - SUMW'($signed(b.re));
        d_im = SUMW'($signed(a.im)) - SUMW'($signed(b.im));
        m_re = PW'(d_re) * PW'($signed(w.re)) - PW'(d_im) * PW'($signed(w.im));
        m_im = PW'(d_re) * PW'($signed(w.im)) + PW'(d_im) * PW'($signed(w.re));
        // both outputs carry a factor of 1/2
        p.re = DW'(s_re >>> 1);
        p.im = DW'(s_im >>> 1);
        q.re = DW'(m_re >>> TWW);
        q.im = DW'(m_im >>> TWW);
    end
endmodule

// File: rtl/fft_ram.sv
module fft_ram
    import fft_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] wa,
    input  samp_t         wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] wb,
    input  samp_t         wd_b,
    input  logic [AW-1:0] ra,
    output samp_t         rd_a,
    input  logic [AW-1:0] rb,
    output samp_t         rd_b
);
    samp_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[wa] <= wd_a;
        if (we_b) mem[wb] <= wd_b;
    end

    assign rd_a = mem[ra];
    assign rd_b = mem[rb];
endmodule

// File: rtl/fft_engine.sv
module fft_engine
    import fft_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 inverse,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic                 out_last,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im,
    output logic                 done
);
    localparam int LG    = $clog2(N);
    localparam int SW    = $clog2(LG);
    localparam int BW    = LG - 1;
    localparam int HALFN = N / 2;
    localparam int FIN   = LG % 2;

    eng_state_t    state_q;
    logic [LG-1:0] cnt_q;
    logic [BW-1:0] bf_q;
    logic [SW-1:0] stage_q;
    logic          inv_q;
    logic          done_q;

    logic [LG-1:0] idx_a, idx_b, ra;
    logic [BW-1:0] tw_idx;
    twid_t         tw_raw, tw_use;
    samp_t         op_a, op_b, res_p, res_q, in_s;
    logic          src;

    samp_t         rd_a [2];
    samp_t         rd_b [2];
    logic          we_a [2];
    logic          we_b [2];
    logic [LG-1:0] wa   [2];
    samp_t         wd_a [2];

    function automatic logic [LG-1:0] bitrev(input logic [LG-1:0] v);
        logic [LG-1:0] r;
        for (int i = 0; i < LG; i++) r[i] = v[LG-1-i];
        return r;
    endfunction

    // sequencing: load N samples, LG passes of N/2 butterflies, drain N bins
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bf_q    <= '0;
            stage_q <= '0;
            inv_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_LOAD;
                        inv_q   <= inverse;
                        cnt_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LG'(N - 1)) begin
                            state_q <= ST_CALC;
                            stage_q <= '0;
                            bf_q    <= '0;
                        end
                    end
                end
                ST_CALC: begin
                    bf_q <= bf_q + 1'b1;
                    if (bf_q == BW'(HALFN - 1)) begin
                        if (stage_q == SW'(LG - 1)) begin
                            state_q <= ST_DRAIN;
                            cnt_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            stage_q <= stage_q + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LG'(N - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fft_addr_gen #(.N(N), .LG(LG), .SW(SW), .BW(BW)) i_addr (
        .stage  (stage_q),
        .bf     (bf_q),
        .idx_a  (idx_a),
        .idx_b  (idx_b),
        .tw_idx (tw_idx)
    );

    fft_twiddle_rom #(.N(N), .IW(BW)) i_rom (
        .idx (tw_idx),
        .w   (tw_raw)
    );

    // the inverse transform uses conjugated twiddles
    assign tw_use.re = tw_raw.re;
    assign tw_use.im = inv_q ? -tw_raw.im : tw_raw.im;

    assign src  = stage_q[0];
    assign ra   = (state_q == ST_DRAIN) ? bitrev(cnt_q) : idx_a;
    assign in_s = '{re: in_re, im: in_im};

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam bit LOAD_BANK = (g == 0);
        logic is_dst, load_here;
        assign is_dst    = (state_q == ST_CALC) && (src != 1'(g));
        assign load_here = LOAD_BANK && (state_q == ST_LOAD) && in_valid;
        assign we_a[g]   = load_here || is_dst;
        assign we_b[g]   = is_dst;
        assign wa[g]     = load_here ? cnt_q : idx_a;
        assign wd_a[g]   = load_here ? in_s : res_p;

        fft_ram #(.DEPTH(N), .AW(LG)) i_ram (
            .clk  (clk),
            .we_a (we_a[g]),
            .wa   (wa[g]),
            .wd_a (wd_a[g]),
            .we_b (we_b[g]),
            .wb   (idx_b),
            .wd_b (res_q),
            .ra   (ra),
            .rd_a (rd_a[g]),
            .rb   (idx_b),
            .rd_b (rd_b[g])
        );
    end

    assign op_a = src ? rd_a[1] : rd_a[0];
    assign op_b = src ? rd_b[1] : rd_b[0];

    fft_butterfly i_bfly (
        .a (op_a),
        .b (op_b),
        .w (tw_use),
        .p (res_p),
        .q (res_q)
    );

    assign out_valid = (state_q == ST_DRAIN);
    assign out_last  = (state_q == ST_DRAIN) && (cnt_q == LG'(N - 1));
    assign out_re    = rd_a[FIN].re;
    assign out_im    = rd_a[FIN].im;
    assign done      = done_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    done_first_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid);
    // R7
    last_end_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_valid);
    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CALC && start) |=> (state_q == ST_CALC || state_q == ST_DRAIN));
    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(inv_q));
    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CALC) |-> (idx_a < idx_b));
    // R3
    wr_port_chk: assert property (@(posedge clk) disable iff (rst)
        (we_a[0] && we_b[0]) |-> (wa[0] != idx_b));
endmodule

// File: tb/test_fft_engine.sv
module test_fft_engine;
    import fft_pkg::*;

    localparam int  N   = 8;
    localparam int  LG  = $clog2(N);
    localparam int  LAT = LG * N / 2;
    localparam real TOL = 4.0;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, inverse = 1'b0, in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic out_valid, out_last, done;
    logic signed [DW-1:0] out_re, out_im;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int xr [N];
    int xi [N];
    int seed = 12345;

    always #10 clk = ~clk;

    fft_engine #(.N(N)) i_fft_engine (
        .clk(clk), .rst(rst), .start(start), .inverse(inverse),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_last(out_last),
        .out_re(out_re), .out_im(out_im), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected <= 20000)", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string msg);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int lcg();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed % 40001) - 20000;
    endfunction

    // drive a frame and check every output bin against a direct DFT
    task automatic run_frame(input bit inv_mode, input bit flip_inv,
                             input bit gaps, input bit poke, input string tag);
        int lat;
        real er, ei, ang, sg;
        @(negedge clk);
        start = 1'b1; inverse = inv_mode;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < N; n++) begin
            if (gaps && (n == 2 || n == 5)) begin
                in_valid = 1'b0; in_re = 16'sd9999; in_im = -16'sd9999;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_re = DW'(xr[n]); in_im = DW'(xi[n]);
            if (flip_inv) inverse = ~inv_mode;
            @(negedge clk);
        end
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 100) begin
            if (poke) begin
                start    = (lat == 2 || lat == LAT - 1);
                in_valid = (lat == 4 || lat == 5);
                in_re    = 16'sd12000; in_im = 16'sd12000;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0; in_valid = 1'b0;
        // R6 first bin due LG*N/2 cycles after the last accepted sample
        check(lat == LAT, $sformatf("R6 %s latency actual %0d expected %0d", tag, lat, LAT));
        sg = inv_mode ? 1.0 : -1.0;
        for (int k = 0; k < N; k++) begin
            er = 0.0; ei = 0.0;
            for (int n = 0; n < N; n++) begin
                ang = TWO_PI * real'(k * n) / real'(N);
                er += real'(xr[n]) * $cos(ang) - sg * real'(xi[n]) * $sin(ang);
                ei += real'(xi[n]) * $cos(ang) + sg * real'(xr[n]) * $sin(ang);
            end
            er = er / real'(N); ei = ei / real'(N);
            // R7 contiguous valid, last on the final bin; R8 done on first bin
            check(out_valid && (out_last == (k == N - 1)) && (done == (k == 0)),
                  $sformatf("R7/R8 %s bin %0d valid/last/done actual %0b%0b%0b expected 1%0b%0b",
                            tag, k, out_valid, out_last, done, k == N - 1, k == 0));
            // R3 forward / R4 inverse bin value
            check((real'(out_re) - er <= TOL) && (er - real'(out_re) <= TOL) &&
                  (real'(out_im) - ei <= TOL) && (ei - real'(out_im) <= TOL),
                  $sformatf("%s %s bin %0d actual (%0d,%0d) expected (%0.1f,%0.1f)",
                            inv_mode ? "R4" : "R3", tag, k, out_re, out_im, er, ei));
            @(negedge clk);
        end
        // R7 valid ends after N bins; R9 engine is idle again
        check(!out_valid && !out_last && !done,
              $sformatf("R7/R9 %s after frame valid actual %0b expected 0", tag, out_valid));
        repeat (3) @(negedge clk);
        check(!out_valid, $sformatf("R9 %s stays idle actual %0b expected 0", tag, out_valid));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs quiet during reset
        check(!out_valid && !out_last && !done,
              $sformatf("R1 in reset valid/last/done actual %0b%0b%0b expected 000", out_valid, out_last, done));
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !done, "R1 after reset release expected idle");
        // R2 in_valid while idle has no effect
        in_valid = 1'b1; in_re = 16'sd5000;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check(!out_valid, $sformatf("R2 idle samples ignored actual valid %0b expected 0", out_valid));

        for (int n = 0; n < N; n++) begin xr[n] = (n == 0) ? 20000 : 0; xi[n] = 0; end
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, "impulse0");
        for (int n = 0; n < N; n++) begin xr[n] = (n == 3) ? 16000 : 0; xi[n] = (n == 3) ? -9000 : 0; end
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, "impulse3");
        for (int n = 0; n < N; n++) begin xr[n] = 16000; xi[n] = -7000; end
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, "dc");
        for (int k = 0; k < N; k++) begin
            for (int n = 0; n < N; n++) begin
                xr[n] = round_q(20000.0 * $cos(TWO_PI * real'(k * n) / real'(N)));
                xi[n] = round_q(20000.0 * $sin(TWO_PI * real'(k * n) / real'(N)));
            end
            run_frame(1'b0, 1'b0, 1'b0, 1'b0, $sformatf("tone%0d", k));
            run_frame(1'b1, 1'b0, 1'b0, 1'b0, $sformatf("itone%0d", k));
        end
        for (int r = 0; r < 6; r++) begin
            for (int n = 0; n < N; n++) begin xr[n] = lcg() * 7 / 10; xi[n] = lcg() * 7 / 10; end
            run_frame(1'b0, 1'b0, 1'b0, 1'b0, $sformatf("rand%0d", r));
            run_frame(1'b1, 1'b0, 1'b0, 1'b0, $sformatf("irand%0d", r));
        end
        // R2 gaps in in_valid during loading skip cycles
        run_frame(1'b0, 1'b0, 1'b1, 1'b0, "R2_gaps");
        // R5 inverse toggled after start has no effect
        run_frame(1'b0, 1'b1, 1'b0, 1'b0, "R5_fwd_flip");
        run_frame(1'b1, 1'b1, 1'b0, 1'b0, "R5_inv_flip");
        // R9 start and stray samples while computing are ignored
        run_frame(1'b0, 1'b0, 1'b0, 1'b1, "R9_poke");
        run_frame(1'b1, 1'b0, 1'b1, 1'b1, "R9_ipoke");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule